// File: doc/BRIEF.md
# Indirect User-RAM Port with Auto-Increment

This block puts a 256-byte scratch RAM behind a small byte-wide register window. Nothing in the RAM is directly addressable from the bus. Software first loads a pointer register with an 8-bit RAM location. It then moves bytes through a single data window: each write to the window stores a byte at the pointer, and each read from the window returns the byte at the pointer.

A streaming flag lives in bit 5 of a control register that the block shares with neighbouring logic. While the flag is set, every data-window access advances the pointer by one, so a block of bytes can be copied with one pointer load. The access itself always uses the pointer value from before the advance. The pointer wraps from 0xFF to 0x00. While the flag is clear, repeated window accesses stay on the same location. The usual multi-byte sequence is: set the streaming flag, load the start location, then issue the window accesses.

Read data is returned one clock after the request, qualified by a one-cycle valid strobe.

Top module: `nvram_port`

## Requirements
- R1: During and directly after reset, the pointer is 0x00, the streaming flag is clear, and `bus_rvalid` is low.
- R2: A bus write to offset 0x10 loads the pointer with `bus_wdata`. A bus read of offset 0x10 returns the current pointer value, including any advances made by earlier window accesses.
- R3: A bus write to offset 0x0F stores `bus_wdata[5]` as the streaming flag. A read of offset 0x0F returns the flag in bit 5, with every other bit reading as 0.
- R4: A bus write to offset 0x13 stores the byte in the RAM at the pointer. A bus read of offset 0x13 returns the RAM byte at the pointer.
- R5: With the streaming flag clear, a data-window access leaves the pointer unchanged, so repeated accesses reach the same RAM location.
- R6: With the streaming flag set, each data-window access, read or write, advances the pointer by one after the access. The access itself uses the pointer value from before the advance.
- R7: An advance from pointer 0xFF gives 0x00.
- R8: A write to any other offset changes neither the pointer, nor the flag, nor the RAM. A read of any other offset returns 0x00.
- R9: `bus_rvalid` is high for exactly one cycle, the cycle after each read request. Write requests and idle cycles never raise it. `bus_rdata` holds the result while `bus_rvalid` is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all state changes on the rising edge |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_sel | input | 1 | Request strobe, one access per cycle while high |
| bus_wr | input | 1 | 1 = write request, 0 = read request |
| bus_addr | input | 5 | Register offset within the window |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read result, valid while `bus_rvalid` is high |
| bus_rvalid | output | 1 | One-cycle strobe marking the read result |

## Verification
A corrupted pointer is visible at the ports at the next readback of offset 0x10, one cycle after the request. It also shows earlier, as a wrong byte on the next data-window read. A missed or extra advance in streaming mode moves every following byte of a burst by one position, so a filled RAM with distinct contents exposes it on the first read after the fault. A flag that is lost or falsely set shows on the next read of offset 0x0F, and from then on as wrong pointer motion. Unmapped-offset writes are checked by reading back the pointer, the flag and the RAM after them.

// File: rtl/nvp_pkg.sv
package nvp_pkg;

   localparam int unsigned NVP_DATA_W    = 8;
   localparam int unsigned NVP_ADDR_W    = 8;
   localparam int unsigned NVP_BUS_AW    = 5;
   localparam int unsigned NVP_OFS_CTRL  = 15;
   localparam int unsigned NVP_OFS_PTR   = 16;
   localparam int unsigned NVP_OFS_DATA  = 19;
   localparam int unsigned NVP_BURST_BIT = 5;

   typedef enum logic [1:0] {
      ACC_NONE = 2'd0,
      ACC_PTR  = 2'd1,
      ACC_CTRL = 2'd2,
      ACC_DATA = 2'd3
   } acc_kind_t;

endpackage

// File: rtl/nvp_decode.sv
module nvp_decode
   import nvp_pkg::*;
#(
   parameter int unsigned BUS_AW   = NVP_BUS_AW,
   parameter int unsigned CTRL_OFS = NVP_OFS_CTRL,
   parameter int unsigned PTR_OFS  = NVP_OFS_PTR,
   parameter int unsigned DATA_OFS = NVP_OFS_DATA
) (
   input  logic              sel,
   input  logic              wr,
   input  logic [BUS_AW-1:0] addr,
   output acc_kind_t         kind,
   output logic              ptr_load,
   output logic              ctrl_load,
   output logic              data_wr,
   output logic              data_acc,
   output logic              rd_go
);

   localparam logic [BUS_AW-1:0] CTRL_A = CTRL_OFS[BUS_AW-1:0];
   localparam logic [BUS_AW-1:0] PTR_A  = PTR_OFS[BUS_AW-1:0];
   localparam logic [BUS_AW-1:0] DATA_A = DATA_OFS[BUS_AW-1:0];

   always_comb begin
      kind = ACC_NONE;
      if (sel) begin
         if (addr == PTR_A)       kind = ACC_PTR;
         else if (addr == CTRL_A) kind = ACC_CTRL;
         else if (addr == DATA_A) kind = ACC_DATA;
      end
   end

   assign ptr_load  = sel && wr && (kind == ACC_PTR);
   assign ctrl_load = sel && wr && (kind == ACC_CTRL);
   assign data_wr   = sel && wr && (kind == ACC_DATA);
   assign data_acc  = (kind == ACC_DATA);
   assign rd_go     = sel && !wr;

endmodule

// File: rtl/nvp_ptr.sv
module nvp_ptr #(
   parameter int unsigned ADDR_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load,
   input  logic [ADDR_W-1:0] load_val,
   input  logic              step,
   output logic [ADDR_W-1:0] ptr_q
);

   localparam logic [ADDR_W-1:0] ONE = ADDR_W'(1);

   logic [ADDR_W-1:0] ptr_d;

   always_comb begin
      ptr_d = ptr_q;
      if (load)      ptr_d = load_val;
      else if (step) ptr_d = ptr_q + ONE;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) ptr_q <= '0;
      else        ptr_q <= ptr_d;
   end

endmodule

// File: rtl/nvp_ram.sv
module nvp_ram #(
   parameter int unsigned DATA_W = 8,
   parameter int unsigned ADDR_W = 8
) (
   input  logic              clk,
   input  logic              we,
   input  logic              re,
   input  logic [ADDR_W-1:0] addr,
   input  logic [DATA_W-1:0] wdata,
   output logic [DATA_W-1:0] rdata
);

   localparam int unsigned DEPTH = 1 << ADDR_W;

   logic [DATA_W-1:0] mem [DEPTH];

   always_ff @(posedge clk) begin
      if (we) mem[addr] <= wdata;
   end

   always_ff @(posedge clk) begin
      if (re) rdata <= mem[addr];
   end

endmodule

// File: rtl/nvp_rdpath.sv
module nvp_rdpath
   import nvp_pkg::*;
#(
   parameter int unsigned DATA_W    = 8,
   parameter int unsigned ADDR_W    = 8,
   parameter int unsigned BURST_BIT = 5,
   parameter bit          RD_PIPE   = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              rd_go,
   input  acc_kind_t         rd_kind,
   input  logic [ADDR_W-1:0] ptr,
   input  logic              burst,
   input  logic [DATA_W-1:0] ram_q,
   output logic [DATA_W-1:0] rdata,
   output logic              rvalid
);

   logic [DATA_W-1:0] snap_d;
   logic [DATA_W-1:0] snap_q;
   logic              use_ram_q;
   logic              v1_q;
   logic [DATA_W-1:0] result;

   always_comb begin
      snap_d = '0;
      unique case (rd_kind)
         ACC_PTR:  snap_d[ADDR_W-1:0] = ptr;
         ACC_CTRL: snap_d[BURST_BIT]  = burst;
         default:  snap_d             = '0;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         v1_q      <= 1'b0;
         use_ram_q <= 1'b0;
         snap_q    <= '0;
      end else begin
         v1_q <= rd_go;
         if (rd_go) begin
            use_ram_q <= (rd_kind == ACC_DATA);
            snap_q    <= snap_d;
         end
      end
   end

   assign result = use_ram_q ? ram_q : snap_q;

   generate
      if (RD_PIPE) begin : g_piped
         logic [DATA_W-1:0] rdata_q;
         logic              rvalid_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               rdata_q  <= '0;
               rvalid_q <= 1'b0;
            end else begin
               rvalid_q <= v1_q;
               if (v1_q) rdata_q <= result;
            end
         end
         assign rdata  = rdata_q;
         assign rvalid = rvalid_q;
      end else begin : g_direct
         assign rdata  = result;
         assign rvalid = v1_q;
      end
   endgenerate

endmodule

// File: rtl/nvram_port.sv
module nvram_port
   import nvp_pkg::*;
#(
   parameter int unsigned DATA_W    = NVP_DATA_W,
   parameter int unsigned ADDR_W    = NVP_ADDR_W,
   parameter int unsigned BUS_AW    = NVP_BUS_AW,
   parameter int unsigned CTRL_OFS  = NVP_OFS_CTRL,
   parameter int unsigned PTR_OFS   = NVP_OFS_PTR,
   parameter int unsigned DATA_OFS  = NVP_OFS_DATA,
   parameter int unsigned BURST_BIT = NVP_BURST_BIT,
   parameter bit          RD_PIPE   = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_sel,
   input  logic              bus_wr,
   input  logic [BUS_AW-1:0] bus_addr,
   input  logic [DATA_W-1:0] bus_wdata,
   output logic [DATA_W-1:0] bus_rdata,
   output logic              bus_rvalid
);

   localparam int unsigned WINDOW = 1 << BUS_AW;

   generate
      if (ADDR_W > DATA_W) begin : g_bad_aw
         $error("nvram_port: pointer wider than the data bus");
      end
      if (BURST_BIT >= DATA_W) begin : g_bad_bit
         $error("nvram_port: streaming flag outside the data bus");
      end
      if (CTRL_OFS >= WINDOW || PTR_OFS >= WINDOW || DATA_OFS >= WINDOW) begin : g_bad_ofs
         $error("nvram_port: register offset outside the window");
      end
      if (CTRL_OFS == PTR_OFS || CTRL_OFS == DATA_OFS || PTR_OFS == DATA_OFS) begin : g_dup_ofs
         $error("nvram_port: register offsets overlap");
      end
   endgenerate

   acc_kind_t         kind;
   logic              ptr_load;
   logic              ctrl_load;
   logic              data_wr;
   logic              data_acc;
   logic              rd_go;
   logic              burst_q;
   logic [ADDR_W-1:0] ptr_q;
   logic [DATA_W-1:0] ram_q;

   nvp_decode #(
      .BUS_AW   (BUS_AW),
      .CTRL_OFS (CTRL_OFS),
      .PTR_OFS  (PTR_OFS),
      .DATA_OFS (DATA_OFS)
   ) u_decode (
      .sel       (bus_sel),
      .wr        (bus_wr),
      .addr      (bus_addr),
      .kind      (kind),
      .ptr_load  (ptr_load),
      .ctrl_load (ctrl_load),
      .data_wr   (data_wr),
      .data_acc  (data_acc),
      .rd_go     (rd_go)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         burst_q <= 1'b0;
      else if (ctrl_load) burst_q <= bus_wdata[BURST_BIT];
   end

   nvp_ptr #(
      .ADDR_W (ADDR_W)
   ) u_ptr (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (ptr_load),
      .load_val (bus_wdata[ADDR_W-1:0]),
      .step     (data_acc && burst_q),
      .ptr_q    (ptr_q)
   );

   nvp_ram #(
      .DATA_W (DATA_W),
      .ADDR_W (ADDR_W)
   ) u_ram (
      .clk   (clk),
      .we    (data_wr),
      .re    (data_acc && !bus_wr),
      .addr  (ptr_q),
      .wdata (bus_wdata),
      .rdata (ram_q)
   );

   nvp_rdpath #(
      .DATA_W    (DATA_W),
      .ADDR_W    (ADDR_W),
      .BURST_BIT (BURST_BIT),
      .RD_PIPE   (RD_PIPE)
   ) u_rdpath (
      .clk     (clk),
      .rst_n   (rst_n),
      .rd_go   (rd_go),
      .rd_kind (kind),
      .ptr     (ptr_q),
      .burst   (burst_q),
      .ram_q   (ram_q),
      .rdata   (bus_rdata),
      .rvalid  (bus_rvalid)
   );

endmodule

// File: rtl/nvram_port_chk.sv
module nvram_port_chk #(
   parameter int unsigned DATA_W   = 8,
   parameter int unsigned ADDR_W   = 8,
   parameter int unsigned BUS_AW   = 5,
   parameter int unsigned CTRL_OFS = 15,
   parameter int unsigned PTR_OFS  = 16,
   parameter int unsigned DATA_OFS = 19,
   parameter bit          RD_PIPE  = 1'b0
) (
   input logic              clk,
   input logic              rst_n,
   input logic              bus_sel,
   input logic              bus_wr,
   input logic [BUS_AW-1:0] bus_addr,
   input logic [DATA_W-1:0] bus_wdata,
   input logic              bus_rvalid,
   input logic [ADDR_W-1:0] ptr_q,
   input logic              burst_q
);

   localparam logic [BUS_AW-1:0] CTRL_A = CTRL_OFS[BUS_AW-1:0];
   localparam logic [BUS_AW-1:0] PTR_A  = PTR_OFS[BUS_AW-1:0];
   localparam logic [BUS_AW-1:0] DATA_A = DATA_OFS[BUS_AW-1:0];

   logic on_data;
   logic on_other;
   assign on_data  = bus_sel && (bus_addr == DATA_A);
   assign on_other = bus_sel && (bus_addr != DATA_A) && (bus_addr != PTR_A)
                     && (bus_addr != CTRL_A);

   // R1
   a_r1_reset_state: assert property (@(posedge clk)
      !rst_n |=> (ptr_q == '0 && !burst_q && !bus_rvalid));

   // R2
   a_r2_ptr_load: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_sel && bus_wr && bus_addr == PTR_A) |=> ptr_q == $past(bus_wdata[ADDR_W-1:0]));

   // R5
   a_r5_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (on_data && !burst_q) |=> $stable(ptr_q));

   // R6 and R7: the sum is truncated to the pointer width, so 0xFF steps to 0x00
   a_r6_step: assert property (@(posedge clk) disable iff (!rst_n)
      (on_data && burst_q) |=> ptr_q == ADDR_W'($past(ptr_q) + 1'b1));

   // R8
   a_r8_ignore: assert property (@(posedge clk) disable iff (!rst_n)
      on_other |=> ($stable(ptr_q) && $stable(burst_q)));

   generate
      if (RD_PIPE) begin : g_lat2
         // R9
         a_r9_rvalid_rd: assert property (@(posedge clk) disable iff (!rst_n)
            (bus_sel && !bus_wr) |=> ##1 bus_rvalid);
         a_r9_rvalid_idle: assert property (@(posedge clk) disable iff (!rst_n)
            !(bus_sel && !bus_wr) |=> ##1 !bus_rvalid);
      end else begin : g_lat1
         // R9
         a_r9_rvalid_rd: assert property (@(posedge clk) disable iff (!rst_n)
            (bus_sel && !bus_wr) |=> bus_rvalid);
         a_r9_rvalid_idle: assert property (@(posedge clk) disable iff (!rst_n)
            !(bus_sel && !bus_wr) |=> !bus_rvalid);
      end
   endgenerate

endmodule

bind nvram_port nvram_port_chk #(
   .DATA_W   (DATA_W),
   .ADDR_W   (ADDR_W),
   .BUS_AW   (BUS_AW),
   .CTRL_OFS (CTRL_OFS),
   .PTR_OFS  (PTR_OFS),
   .DATA_OFS (DATA_OFS),
   .RD_PIPE  (RD_PIPE)
) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .bus_sel    (bus_sel),
   .bus_wr     (bus_wr),
   .bus_addr   (bus_addr),
   .bus_wdata  (bus_wdata),
   .bus_rvalid (bus_rvalid),
   .ptr_q      (ptr_q),
   .burst_q    (burst_q)
);

// File: tb/nvram_port_tb_top.sv
module nvram_port_tb_top;

   localparam logic [4:0] OFS_CTRL = 5'h0F;
   localparam logic [4:0] OFS_PTR  = 5'h10;
   localparam logic [4:0] OFS_DATA = 5'h13;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       bus_sel = 1'b0;
   logic       bus_wr = 1'b0;
   logic [4:0] bus_addr = '0;
   logic [7:0] bus_wdata = '0;
   logic [7:0] bus_rdata;
   logic       bus_rvalid;

   int tests = 0;
   int fails = 0;
   bit done = 1'b0;

   logic [7:0] mem_m [256];
   logic [7:0] ptr_m = 8'h00;
   logic       burst_m = 1'b0;

   always #10 clk = ~clk;

   nvram_port dut_i (
      .clk        (clk),
      .rst_n      (rst_n),
      .bus_sel    (bus_sel),
      .bus_wr     (bus_wr),
      .bus_addr   (bus_addr),
      .bus_wdata  (bus_wdata),
      .bus_rdata  (bus_rdata),
      .bus_rvalid (bus_rvalid)
   );

   task automatic chk(string req, logic [7:0] act, logic [7:0] exp);
      tests++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s: actual %02h expected %02h", req, act, exp);
      end
   endtask

   function automatic logic [7:0] exp_read(logic [4:0] a);
      if (a == OFS_PTR)  return ptr_m;
      if (a == OFS_CTRL) return {2'b00, burst_m, 5'b00000};
      if (a == OFS_DATA) return mem_m[ptr_m];
      return 8'h00;
   endfunction

   function automatic string req_of(logic [4:0] a);
      if (a == OFS_PTR)  return "R2";
      if (a == OFS_CTRL) return "R3";
      if (a == OFS_DATA) return burst_m ? "R6" : "R4";
      return "R8";
   endfunction

   function automatic void model_step();
      if (burst_m) ptr_m = ptr_m + 8'd1;
   endfunction

   // entered and left on a falling edge
   task automatic bus_write(logic [4:0] a, logic [7:0] d);
      bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
      @(negedge clk);
      bus_sel = 1'b0; bus_wr = 1'b0;
      chk("R9", {7'd0, bus_rvalid}, 8'h00);
      if (a == OFS_PTR) ptr_m = d;
      else if (a == OFS_CTRL) burst_m = d[5];
      else if (a == OFS_DATA) begin
         mem_m[ptr_m] = d;
         model_step();
      end
   endtask

   task automatic bus_read(logic [4:0] a, output logic [7:0] d);
      bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
      @(negedge clk);
      bus_sel = 1'b0;
      d = bus_rdata;
      chk("R9", {7'd0, bus_rvalid}, 8'h01);
   endtask

   task automatic read_chk(logic [4:0] a, string req);
      logic [7:0] got;
      logic [7:0] exp;
      exp = exp_read(a);
      bus_read(a, got);
      chk(req, got, exp);
      if (a == OFS_DATA) model_step();
   endtask

   initial begin : watchdog
      repeat (100000) @(posedge clk);
      if (!done) begin
         tests++;
         fails++;
         $display("FAIL watchdog: actual hung expected finished");
         $display("  [TB] %0d tests run, %0d failed", tests, fails);
         $finish;
      end
   end

   initial begin : stim
      logic [7:0] v;
      void'($urandom(32'h1234_abcd));
      for (int i = 0; i < 256; i++) mem_m[i] = 8'h00;

      // R1: reset state
      repeat (3) @(negedge clk);
      chk("R1", {7'd0, bus_rvalid}, 8'h00);
      rst_n = 1'b1;
      @(negedge clk);
      read_chk(OFS_PTR, "R1");
      read_chk(OFS_CTRL, "R1");

      // R3: flag storage, other bits read zero
      bus_write(OFS_CTRL, 8'hDF);
      read_chk(OFS_CTRL, "R3");
      bus_write(OFS_CTRL, 8'h20);
      read_chk(OFS_CTRL, "R3");

      // R6/R7: fill all 256 bytes with one pointer load, then wrap
      bus_write(OFS_PTR, 8'h00);
      for (int i = 0; i < 256; i++) bus_write(OFS_DATA, 8'(i * 37 + 11));
      read_chk(OFS_PTR, "R7");
      for (int i = 0; i < 8; i++) read_chk(OFS_DATA, "R6");
      read_chk(OFS_PTR, "R6");

      // R7: read across the top of the RAM
      bus_write(OFS_PTR, 8'hFE);
      read_chk(OFS_DATA, "R7");
      read_chk(OFS_DATA, "R7");
      read_chk(OFS_PTR, "R7");
      read_chk(OFS_DATA, "R7");

      // R5: flag clear keeps the pointer
      bus_write(OFS_CTRL, 8'h00);
      bus_write(OFS_PTR, 8'h40);
      read_chk(OFS_DATA, "R5");
      read_chk(OFS_DATA, "R5");
      bus_write(OFS_DATA, 8'hA5);
      bus_write(OFS_DATA, 8'h5A);
      read_chk(OFS_PTR, "R5");
      read_chk(OFS_DATA, "R4");
      bus_write(OFS_PTR, 8'h41);
      read_chk(OFS_DATA, "R4");

      // R8: unmapped offsets ignored, read zero
      bus_write(5'h11, 8'h77);
      bus_write(5'h12, 8'hFF);
      bus_write(5'h00, 8'h20);
      read_chk(OFS_PTR, "R8");
      read_chk(OFS_CTRL, "R8");
      read_chk(OFS_DATA, "R8");
      read_chk(5'h12, "R8");
      read_chk(5'h1F, "R8");

      // constrained random mix
      for (int i = 0; i < 600; i++) begin
         logic [4:0] a;
         int unsigned pick;
         pick = $urandom % 8;
         case (pick)
            0:       a = OFS_PTR;
            1:       a = OFS_CTRL;
            2, 3, 4: a = OFS_DATA;
            default: a = 5'($urandom % 32);
         endcase
         if ($urandom % 2) begin
            v = 8'($urandom);
            bus_write(a, v);
         end else begin
            read_chk(a, req_of(a));
         end
      end

      // final readback of the whole RAM in streaming mode
      bus_write(OFS_CTRL, 8'h20);
      bus_write(OFS_PTR, 8'h00);
      for (int i = 0; i < 256; i++) read_chk(OFS_DATA, "R4");
      read_chk(OFS_PTR, "R7");

      done = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end

endmodule